// File: doc/BRIEF.md
# Serial Memory Slave Front-End with Pause Control

This block is the serial-facing edge of a memory slave that speaks SPI in mode 0. It takes the raw chip-select, serial clock, serial data-in and pause (hold) pins, brings them into the system clock domain, and decides when the device is really addressed. Incoming bits are assembled MSB first into bytes, and each complete byte is handed to a downstream command engine with a one-cycle strobe. The engine in turn supplies the byte to be shifted out, together with a request that turns the serial output driver on.

Selection is armed only by a falling edge of chip select that is seen while the supply is good. A chip select that is already low when the supply comes up does nothing until it has gone high and low again. A pause can be started and ended only while the serial clock is low. During a pause the output driver is off and the clock and data pins are ignored, but the partial byte is kept. Raising chip select during a pause clears the whole transfer state. A supply-good input stands in for the power-on detector, and standby is reported when the device is deselected and no write cycle is flagged.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset, and after every return of `supply_ok`, `selected` stays 0 until a high-to-low transition of the synchronized `cs_n` has been seen. A `cs_n` held low across power-up gives no selection and no byte strobes.
- R2: While `supply_ok` is 0, `selected`, `sdo_oe` and `rx_valid` are 0 in the same cycle, and clocking in bits produces no byte strobes.
- R3: `cs_n` high deselects. `standby` is 1 exactly when the device is not selected and `wr_busy` is 0.
- R4: A pause (`in_hold`=1) starts only while selected, with the synchronized `hold_n` low and the synchronized `sck` low.
- R5: A pause ends only when the synchronized `hold_n` is high while the synchronized `sck` is low, or when the device is deselected or loses supply.
- R6: During a pause `sdo_oe` is 0, and edges on `sck` and `sdi` are ignored. The bit count and partial byte are kept, so the byte resumes where it stopped.
- R7: Raising `cs_n` during a pause clears the pause, the bit count and the partial byte. The next selection starts from bit 0.
- R8: A `hold_n` change made while `sck` is high takes effect only once `sck` is low again. This applies both to starting and to ending a pause.
- R9: `sdi` is sampled on rising `sck` edges, MSB first. After every eighth sampled bit, `rx_valid` pulses for one system cycle, and `rx_byte` holds the assembled byte.
- R10: `sdo` carries `tx_byte` MSB first. The first byte is the one present at selection, and each bit changes only after a falling `sck` edge. At the falling edge that follows the eighth rising edge, the next `tx_byte` is loaded.
- R11: `sdo_oe` is 1 only when the device is selected, not paused, and `tx_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the power-on threshold |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin, idle low, asynchronous |
| sdi | input | 1 | Serial data-in pin, asynchronous |
| hold_n | input | 1 | Pause pin, active low, asynchronous |
| wr_busy | input | 1 | An internal write cycle is in progress |
| tx_req | input | 1 | Downstream engine wants the output driven |
| tx_byte | input | DATA_W | Byte to shift out next |
| rx_byte | output | DATA_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |
| sdo | output | 1 | Serial data-out value |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |
| selected | output | 1 | Device is selected (active mode) |
| standby | output | 1 | Deselected and no write cycle in progress |
| in_hold | output | 1 | Transfer is paused |

## Verification
The bench uses the defaults DATA_W=8 and SYNC_STAGES=2. With 8-bit bytes, every one of the 256 receive values can be sent in a single selection, each paired with an arithmetically generated transmit byte. This checks MSB-first assembly and the next-byte load at every byte boundary. The two-stage synchronizer keeps pin-to-state latency at a few cycles, so pauses can be placed at chosen bit positions, deferred by holding the clock high, and cut short by deselection.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  // Events detected in the system clock domain.
  typedef struct packed {
    logic cs_fall;
    logic sck_rise;
    logic sck_fall;
  } fe_events_t;

  // Bit position after one more sampled bit, wrapping at the byte width.
  function automatic int bit_after(input int cnt, input int width);
    return (cnt + 1 >= width) ? 0 : cnt + 1;
  endfunction

  // True when the bit about to be sampled completes a byte.
  function automatic logic closes_byte(input int cnt, input int width);
    return (cnt + 1 == width);
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] chain_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
          chain_q[0] <= d;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end

      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cs_n_s,
  input  logic       sck_s,
  input  logic       hold_n_s,
  output logic       sel,
  output logic       hold,
  output fe_events_t ev
);

  logic cs_prev_q;
  logic sck_prev_q;
  logic sel_q;
  logic hold_q;

  // Event wires, brought out by name for the checks below.
  logic cs_fall_w;
  logic sck_rise_w;
  logic sck_fall_w;

  assign cs_fall_w  = supply_ok & cs_prev_q & ~cs_n_s;
  assign sck_rise_w = ~sck_prev_q & sck_s;
  assign sck_fall_w = sck_prev_q & ~sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      sel_q      <= 1'b0;
      hold_q     <= 1'b0;
    end else if (!supply_ok) begin
      // Forget the last chip-select level: a low pin must rise again.
      cs_prev_q  <= 1'b0;
      sck_prev_q <= sck_s;
      sel_q      <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      cs_prev_q  <= cs_n_s;
      sck_prev_q <= sck_s;
      if (cs_n_s) begin
        sel_q  <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        if (cs_fall_w) sel_q <= 1'b1;
        // The pause pin is only looked at while the serial clock is low.
        if (sel_q && !sck_s) hold_q <= ~hold_n_s;
      end
    end
  end

  assign sel = sel_q & supply_ok;
  assign hold = hold_q & sel;
  assign ev.cs_fall  = cs_fall_w;
  assign ev.sck_rise = sck_rise_w;
  assign ev.sck_fall = sck_fall_w;

  AST_SEL_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> $past(cs_fall_w)); // R1

  AST_SUPPLY_DROP_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !sel_q && !hold_q); // R2

  AST_HOLD_ENTRY_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(sel_q && !sck_s && !hold_n_s)); // R4

  AST_HOLD_EXIT_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(cs_n_s || !supply_ok || (!sck_s && hold_n_s))); // R5

  AST_HOLD_KEPT_WHILE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_s && supply_ok && !cs_n_s) |=> $stable(hold_q)); // R8

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              hold,
  input  fe_events_t        ev,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              sdo
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [DATA_W-1:0] rx_q;
  logic              rx_valid_q;
  logic [DATA_W-1:0] tx_q;

  logic              active_w;
  logic              take_bit_w;
  logic              shift_out_w;
  logic              byte_done_w;
  logic [DATA_W-1:0] rx_next_w;

  assign active_w    = sel & ~hold;
  assign take_bit_w  = active_w & ev.sck_rise;
  assign shift_out_w = active_w & ev.sck_fall;
  assign byte_done_w = take_bit_w & closes_byte(int'(cnt_q), DATA_W);
  assign rx_next_w   = {rx_sh_q[DATA_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      rx_q       <= '0;
      rx_valid_q <= 1'b0;
      tx_q       <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (!sel) begin
        cnt_q   <= '0;
        rx_sh_q <= '0;
        tx_q    <= tx_byte;
      end else begin
        if (take_bit_w) begin
          rx_sh_q <= rx_next_w;
          cnt_q   <= CNT_W'(bit_after(int'(cnt_q), DATA_W));
        end
        if (byte_done_w) begin
          rx_q       <= rx_next_w;
          rx_valid_q <= 1'b1;
        end
        if (shift_out_w) begin
          if (cnt_q == '0) tx_q <= tx_byte;
          else             tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rx_byte  = rx_q;
  assign rx_valid = rx_valid_q;
  assign sdo      = tx_q[DATA_W-1];

  AST_HOLD_FREEZES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hold) |=> $stable(cnt_q) && $stable(rx_sh_q)); // R6

  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt_q == '0) && (rx_sh_q == '0)); // R7

  AST_STROBE_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> $past(sel && !hold && ev.sck_rise && cnt_q == LAST_BIT)); // R9

  AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |=> !rx_valid_q); // R9

  AST_OUTPUT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !ev.sck_fall) |=> $stable(tx_q)); // R10

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              hold_n,
  input  logic              wr_busy,
  input  logic              tx_req,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              selected,
  output logic              standby,
  output logic              in_hold
);

  localparam int PIN_W = 4;

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  logic             cs_n_s;
  logic             sck_s;
  logic             sdi_s;
  logic             hold_n_s;

  logic             sel_w;
  logic             hold_w;
  fe_events_t       ev_w;
  logic             rx_valid_w;

  assign pins_raw = {cs_n, sck, sdi, hold_n};

  spi_fe_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign {cs_n_s, sck_s, sdi_s, hold_n_s} = pins_s;

  spi_fe_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .cs_n_s    (cs_n_s),
    .sck_s     (sck_s),
    .hold_n_s  (hold_n_s),
    .sel       (sel_w),
    .hold      (hold_w),
    .ev        (ev_w)
  );

  spi_fe_shift #(
    .DATA_W (DATA_W)
  ) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel_w),
    .hold     (hold_w),
    .ev       (ev_w),
    .sdi_s    (sdi_s),
    .tx_byte  (tx_byte),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid_w),
    .sdo      (sdo)
  );

  assign rx_valid = rx_valid_w & supply_ok;
  assign selected = sel_w;
  assign in_hold  = hold_w;
  assign standby  = ~sel_w & ~wr_busy;
  assign sdo_oe   = sel_w & ~hold_w & tx_req;

  AST_STANDBY_NOT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !selected && !in_hold); // R3

  AST_NO_DRIVE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> !sdo_oe); // R6

  AST_NO_STROBE_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !rx_valid && !selected && !sdo_oe); // R2

endmodule

// File: tb/spi_mem_frontend_tb_top.sv
module spi_mem_frontend_tb_top;

  localparam int DATA_W = 8;
  localparam int HALF   = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              supply_ok = 1'b1;
  logic              cs_n = 1'b0;
  logic              sck = 1'b0;
  logic              sdi = 1'b0;
  logic              hold_n = 1'b1;
  logic              wr_busy = 1'b0;
  logic              tx_req = 1'b0;
  logic [DATA_W-1:0] tx_byte = '0;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_valid;
  logic              sdo;
  logic              sdo_oe;
  logic              selected;
  logic              standby;
  logic              in_hold;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  logic [DATA_W-1:0] last_rx = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_mem_frontend #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n), .sck(sck),
    .sdi(sdi), .hold_n(hold_n), .wr_busy(wr_busy), .tx_req(tx_req),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_valid(rx_valid), .sdo(sdo),
    .sdo_oe(sdo_oe), .selected(selected), .standby(standby), .in_hold(in_hold)
  );

  // Strobe monitor, sampled in the middle of the high phase.
  always @(posedge clk) begin
    #5;
    if (rx_valid) begin
      pulses  = pulses + 1;
      last_rx = rx_byte;
    end
  end

  function automatic logic [DATA_W-1:0] tx_pattern(input int v);
    return DATA_W'((v * 37 + 11) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_bit(input logic d, output logic seen);
    sdi = d;
    wait_clk(HALF);
    seen = sdo;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_bits(input logic [DATA_W-1:0] d, input int hi, input int lo);
    logic seen;
    for (int i = hi; i >= lo; i--) one_bit(d[i], seen);
  endtask

  task automatic send_byte(input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] next_tx,
                           output logic [DATA_W-1:0] got);
    for (int i = DATA_W - 1; i >= 0; i--) begin
      sdi = d[i];
      wait_clk(HALF);
      got[i] = sdo;
      sck = 1'b1;
      wait_clk(HALF);
      if (i == 0) tx_byte = next_tx;
      sck = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic reselect();
    cs_n = 1'b1;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] got;
    int p0;

    // Reset with chip select already low.
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    check(selected == 1'b0, "R1", "selected with cs_n low at power-up", int'(selected), 0);
    check(standby == 1'b1, "R3", "standby after reset", int'(standby), 1);
    check(sdo_oe == 1'b0, "R11", "sdo_oe after reset", int'(sdo_oe), 0);
    check(rx_valid == 1'b0, "R9", "rx_valid after reset", int'(rx_valid), 0);

    // Clocking while never armed gives nothing.
    send_bits(8'h5A, 7, 0);
    check(pulses == 0, "R1", "strobes while unarmed", pulses, 0);
    check(selected == 1'b0, "R1", "still unselected", int'(selected), 0);

    // Arm with a real falling edge.
    tx_byte = tx_pattern(0);
    reselect();
    check(selected == 1'b1, "R1", "selected after cs_n falling edge", int'(selected), 1);
    check(standby == 1'b0, "R3", "standby while selected", int'(standby), 0);
    check(sdo_oe == 1'b0, "R11", "sdo_oe without tx_req", int'(sdo_oe), 0);
    tx_req = 1'b1;
    wait_clk(1);
    check(sdo_oe == 1'b1, "R11", "sdo_oe with tx_req", int'(sdo_oe), 1);

    // Exhaustive byte sweep in one selection.
    for (int v = 0; v < 256; v++) begin
      p0 = pulses;
      send_byte(DATA_W'(v), tx_pattern(v + 1), got);
      check(pulses == p0 + 1, "R9", "one strobe per byte", pulses - p0, 1);
      check(last_rx == DATA_W'(v), "R9", "received byte", int'(last_rx), v);
      check(got == tx_pattern(v), "R10", "transmitted byte", int'(got), int'(tx_pattern(v)));
    end

    // Deselect and standby.
    cs_n = 1'b1;
    wait_clk(HALF);
    check(selected == 1'b0, "R3", "deselected by cs_n high", int'(selected), 0);
    check(standby == 1'b1, "R3", "standby when idle", int'(standby), 1);
    wr_busy = 1'b1;
    wait_clk(1);
    check(standby == 1'b0, "R3", "no standby during write", int'(standby), 0);
    wr_busy = 1'b0;

    // Pause in the middle of a byte.
    cs_n = 1'b0;
    wait_clk(HALF);
    p0 = pulses;
    send_bits(8'hB6, 7, 5);
    hold_n = 1'b0;
    wait_clk(HALF);
    check(in_hold == 1'b1, "R4", "pause entered with sck low", int'(in_hold), 1);
    check(sdo_oe == 1'b0, "R6", "driver off in pause", int'(sdo_oe), 0);
    send_bits(8'hFF, 4, 0);
    check(pulses == p0, "R6", "clock ignored in pause", pulses - p0, 0);
    hold_n = 1'b1;
    wait_clk(HALF);
    check(in_hold == 1'b0, "R5", "pause left with sck low", int'(in_hold), 0);
    send_bits(8'hB6, 4, 0);
    check(pulses == p0 + 1, "R6", "one strobe after resumed byte", pulses - p0, 1);
    check(last_rx == 8'hB6, "R6", "byte resumed where paused", int'(last_rx), 'hB6);

    // Pause pin changes while sck is high are deferred.
    p0 = pulses;
    send_bits(8'h4D, 7, 5);
    sdi = 1'b0;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
    hold_n = 1'b0;
    wait_clk(HALF);
    check(in_hold == 1'b0, "R8", "entry deferred while sck high", int'(in_hold), 0);
    sck = 1'b0;
    wait_clk(HALF);
    check(in_hold == 1'b1, "R8", "entry once sck low", int'(in_hold), 1);
    sdi = 1'b1;
    sck = 1'b1;
    wait_clk(HALF);
    hold_n = 1'b1;
    wait_clk(HALF);
    check(in_hold == 1'b1, "R8", "exit deferred while sck high", int'(in_hold), 1);
    sck = 1'b0;
    wait_clk(HALF);
    check(in_hold == 1'b0, "R5", "exit once sck low", int'(in_hold), 0);
    send_bits(8'h4D, 3, 0);
    check(pulses == p0 + 1 && last_rx == 8'h4D, "R8", "byte across deferred pause",
          int'(last_rx), 'h4D);

    // Deselect during a pause clears everything.
    p0 = pulses;
    send_bits(8'hFF, 7, 5);
    hold_n = 1'b0;
    wait_clk(HALF);
    check(in_hold == 1'b1, "R7", "paused before deselect", int'(in_hold), 1);
    cs_n = 1'b1;
    wait_clk(HALF);
    check(in_hold == 1'b0 && selected == 1'b0, "R7", "pause cleared by deselect",
          int'(in_hold), 0);
    hold_n = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    send_bits(8'h3C, 7, 0);
    check(pulses == p0 + 1, "R7", "one strobe after fresh select", pulses - p0, 1);
    check(last_rx == 8'h3C, "R7", "partial byte discarded", int'(last_rx), 'h3C);

    // Supply loss.
    supply_ok = 1'b0;
    #1;
    check(selected == 1'b0, "R2", "deselected at once on supply loss", int'(selected), 0);
    check(sdo_oe == 1'b0, "R2", "driver off on supply loss", int'(sdo_oe), 0);
    p0 = pulses;
    send_bits(8'hAA, 7, 0);
    check(pulses == p0, "R2", "no strobes without supply", pulses - p0, 0);
    supply_ok = 1'b1;
    wait_clk(HALF);
    check(selected == 1'b0, "R1", "low cs_n ignored after supply return", int'(selected), 0);
    reselect();
    check(selected == 1'b1, "R1", "selected after new falling edge", int'(selected), 1);
    send_bits(8'h81, 7, 0);
    check(last_rx == 8'h81 && pulses == p0 + 1, "R9", "byte after supply return",
          int'(last_rx), 'h81);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule